// File: doc/BRIEF.md
# Inductive Button Press Decision Logic

This block turns four already baseline-subtracted, signed 12-bit button readings into four press decisions. Each reading first passes through a per-channel direction select, which can flip its sign so that a press always shows as positive. The result is compared against that channel's own threshold. Hysteresis keeps a pressed channel held until its reading drops well below the threshold.

Two cross-channel rules come after the per-channel decision. The first is a veto: if any reading is negative by more than a programmable margin, the whole update reports no presses. This guards against a flexing enclosure. The second rule applies to a set of channels the user marks as mutually exclusive. Among the pressed channels in that set, only the one with the strongest reading is reported. The decisions are registered and change only when a new sample set is flagged valid. A per-pin level select then drives each decision out as an active-high or active-low pin.

Top module: `btn_decide_core`

## Requirements
- R1: While reset is high, and on the first clock edge after it, `btn_state` is all zero. Each `btn_pin` then sits at its released level, which is 1 when its `opol_high` bit is 0.
- R2: A released channel becomes pressed when its effective reading is greater than or equal to its threshold, and stays released when the reading is one below it.
- R3: A pressed channel stays pressed while its effective reading is at least threshold minus 4×`hyst_code`. It releases once the reading falls below that level.
- R4: When `twist_code` is nonzero, the veto applies if any channel's effective reading is below −4×`twist_code`. On that update every `btn_state` bit is 0, but each channel's hysteresis memory is still updated. A reading exactly at −4×`twist_code` does not veto.
- R5: When `twist_code` is 0, no reading, including −2048, vetoes.
- R6: Among the pressed channels whose `maxwin_en` bit is 1, only the one with the largest effective reading is reported, and a tie goes to the lowest channel index. Channels whose bit is 0 are not affected by this rule.
- R7: With `dpol_rise` bit 1, the effective reading is the input word. With bit 0, it is the negated word, and −2048 maps to +2047.
- R8: `btn_pin[i]` equals `btn_state[i]` when `opol_high[i]` is 1, and equals its inverse when the bit is 0. It follows an `opol_high` change without waiting for a clock.
- R9: `btn_state` changes only on the clock edge that samples `data_valid` high, and holds otherwise even if the inputs change.
- R10: Channel i's reading occupies `data_word[12*i+11:12*i]` and its threshold occupies `thresh_word[12*i+11:12*i]`, both two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_valid | input | 1 | A new reading set is present |
| data_word | input | 48 | Four signed 12-bit readings, channel 0 lowest |
| thresh_word | input | 48 | Four signed 12-bit thresholds, channel 0 lowest |
| hyst_code | input | 4 | Hysteresis, in steps of 4 counts |
| twist_code | input | 3 | Veto margin, in steps of 4 counts; 0 turns the veto off |
| maxwin_en | input | 4 | Marks a channel as a member of the exclusive group |
| dpol_rise | input | 4 | 1 uses the reading as is, 0 negates it |
| opol_high | input | 4 | 1 drives the pin active high, 0 active low |
| btn_state | output | 4 | Registered logical press decision per channel |
| btn_pin | output | 4 | Press decision at the selected pin level |

## Verification
Directed steps walk one channel up to its threshold and one count short of it. They then bring it back down to exactly the hysteresis floor and one count under it, so that an off-by-one in either comparison is exposed. Veto readings are placed at the margin and one count past it, and the disabled-veto case uses −2048. The exclusive group is exercised with a clear winner, a three-way tie, and a non-member that is stronger than every member. Negated direction is tried at −2048 to expose a missing saturation. Random sets then mix readings near the threshold with full-range extremes, random masks and random codes, including skipped valid strobes. Every result is compared with a bench model.

// File: rtl/btn_decide_pkg.sv
package btn_decide_pkg;

    localparam int NCH     = 4;
    localparam int DW      = 12;
    localparam int HYST_W  = 4;
    localparam int TWIST_W = 3;
    localparam int CW      = DW + 3;

    typedef logic signed [DW-1:0] bdata_t;
    typedef logic signed [CW-1:0] wide_t;

    localparam bdata_t BD_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam bdata_t BD_MAX = {1'b0, {(DW-1){1'b1}}};

    typedef struct packed {
        bdata_t eff;
        logic   hold_next;
    } lane_res_t;

    // Direction select: negate with saturation when the reading falls on press.
    function automatic bdata_t polar_adjust(input bdata_t d, input logic rise);
        if (rise)            return d;
        else if (d == BD_MIN) return BD_MAX;
        else                 return -d;
    endfunction

    function automatic wide_t widen(input bdata_t d);
        return {{(CW-DW){d[DW-1]}}, d};
    endfunction

    // Code times four, zero-extended to the wide comparison width.
    function automatic wide_t times4(input logic [HYST_W-1:0] code);
        return {{(CW-HYST_W-2){1'b0}}, code, 2'b00};
    endfunction

endpackage

// File: rtl/btn_hyst_lane.sv
module btn_hyst_lane
    import btn_decide_pkg::*;
(
    input  bdata_t             data_raw,
    input  bdata_t             thresh,
    input  logic               rise,
    input  logic [HYST_W-1:0]  hyst_code,
    input  logic               hold_q,
    output lane_res_t          res
);
    bdata_t eff;
    wide_t  e_w;
    wide_t  t_w;
    wide_t  floor_w;

    always_comb begin
        eff     = polar_adjust(data_raw, rise);
        e_w     = widen(eff);
        t_w     = widen(thresh);
        floor_w = t_w - times4(hyst_code);
        res.eff = eff;
        if (hold_q) res.hold_next = (e_w >= floor_w);
        else        res.hold_next = (e_w >= t_w);
    end

endmodule

// File: rtl/btn_twist_veto.sv
module btn_twist_veto
    import btn_decide_pkg::*;
#(
    parameter int N = NCH
) (
    input  bdata_t [N-1:0]      eff,
    input  logic [TWIST_W-1:0]  twist_code,
    output logic                veto
);
    wide_t lim_neg;
    logic  [N-1:0] below;

    always_comb begin
        lim_neg = wide_t'(0) - times4({{(HYST_W-TWIST_W){1'b0}}, twist_code});
    end

    for (genvar i = 0; i < N; i++) begin : g_cmp
        wide_t e_w;
        always_comb begin
            e_w      = widen(eff[i]);
            below[i] = (e_w < lim_neg);
        end
    end

    assign veto = (twist_code != '0) && (|below);

endmodule

// File: rtl/btn_maxwin_sel.sv
module btn_maxwin_sel
    import btn_decide_pkg::*;
#(
    parameter int N  = NCH,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic   [N-1:0] cand,
    input  logic   [N-1:0] group,
    input  bdata_t [N-1:0] eff,
    output logic   [N-1:0] keep
);
    logic          found;
    logic [IW-1:0] best_idx;
    bdata_t        best_val;

    // Strict greater-than keeps the lowest index on ties.
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_val = BD_MIN;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && group[i]) begin
                if (!found || ($signed(eff[i]) > $signed(best_val))) begin
                    found    = 1'b1;
                    best_idx = IW'(i);
                    best_val = eff[i];
                end
            end
        end
        keep = cand & ~group;
        if (found) keep[best_idx] = 1'b1;
    end

endmodule

// File: rtl/btn_decide_core.sv
module btn_decide_core
    import btn_decide_pkg::*;
#(
    parameter int N  = NCH,
    localparam int BW = N * DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               data_valid,
    input  logic [BW-1:0]      data_word,
    input  logic [BW-1:0]      thresh_word,
    input  logic [HYST_W-1:0]  hyst_code,
    input  logic [TWIST_W-1:0] twist_code,
    input  logic [N-1:0]       maxwin_en,
    input  logic [N-1:0]       dpol_rise,
    input  logic [N-1:0]       opol_high,
    output logic [N-1:0]       btn_state,
    output logic [N-1:0]       btn_pin
);
    lane_res_t      res     [N];
    bdata_t [N-1:0] eff_v;
    logic   [N-1:0] hold_next;
    logic   [N-1:0] hold_q;
    logic   [N-1:0] keep;
    logic   [N-1:0] btn_q;
    logic           veto;

    for (genvar i = 0; i < N; i++) begin : g_lane
        btn_hyst_lane u_lane (
            .data_raw  (bdata_t'(data_word[i*DW +: DW])),
            .thresh    (bdata_t'(thresh_word[i*DW +: DW])),
            .rise      (dpol_rise[i]),
            .hyst_code (hyst_code),
            .hold_q    (hold_q[i]),
            .res       (res[i])
        );
        assign eff_v[i]     = res[i].eff;
        assign hold_next[i] = res[i].hold_next;
        assign btn_pin[i]   = opol_high[i] ? btn_q[i] : ~btn_q[i];
    end

    btn_twist_veto #(.N(N)) u_veto (
        .eff        (eff_v),
        .twist_code (twist_code),
        .veto       (veto)
    );

    btn_maxwin_sel #(.N(N)) u_maxwin (
        .cand  (hold_next),
        .group (maxwin_en),
        .eff   (eff_v),
        .keep  (keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            btn_q  <= '0;
        end else if (data_valid) begin
            hold_q <= hold_next;
            btn_q  <= veto ? '0 : keep;
        end
    end

    assign btn_state = btn_q;

    // R1: reset clears the decisions on the next edge
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> btn_state == '0);

    // R9: decisions hold without a valid strobe
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !data_valid |=> $stable(btn_state));

    // R4: a veto on a valid sample leaves no press reported
    a_r4_veto_clear: assert property (@(posedge clk) disable iff (rst)
        (data_valid && veto) |=> btn_state == '0);

    // R6: at most one group member reported after an update
    a_r6_one_winner: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> $countones(btn_state & $past(maxwin_en)) <= 1);

    // R3: a reported press always has its hysteresis memory set
    a_r3_state_in_hold: assert property (@(posedge clk) disable iff (rst)
        (btn_state & ~hold_q) == '0);

endmodule

// File: tb/btn_decide_core_tb_top.sv
module btn_decide_core_tb_top;
    localparam int N  = 4;
    localparam int DW = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            data_valid = 1'b0;
    logic [N*DW-1:0] data_word = '0;
    logic [N*DW-1:0] thresh_word = '0;
    logic [3:0]      hyst_code = 4'd8;
    logic [2:0]      twist_code = '0;
    logic [N-1:0]    maxwin_en = '0;
    logic [N-1:0]    dpol_rise = '1;
    logic [N-1:0]    opol_high = '0;
    logic [N-1:0]    btn_state;
    logic [N-1:0]    btn_pin;

    int dv [N];
    int th [N];
    logic [N-1:0] m_hold = '0;
    logic [N-1:0] m_btn  = '0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    btn_decide_core dut_i (
        .clk(clk), .rst(rst), .data_valid(data_valid),
        .data_word(data_word), .thresh_word(thresh_word),
        .hyst_code(hyst_code), .twist_code(twist_code),
        .maxwin_en(maxwin_en), .dpol_rise(dpol_rise), .opol_high(opol_high),
        .btn_state(btn_state), .btn_pin(btn_pin)
    );

    function automatic int eff_of(int d, bit rise);
        if (rise) return d;
        if (d == -2048) return 2047;
        return -d;
    endfunction

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    function automatic void model_update();
        int  e [N];
        bit  veto;
        int  best;
        logic [N-1:0] hn;
        veto = 0;
        for (int i = 0; i < N; i++) begin
            e[i] = eff_of(dv[i], dpol_rise[i]);
            if (m_hold[i]) hn[i] = (e[i] >= th[i] - 4 * int'(hyst_code));
            else           hn[i] = (e[i] >= th[i]);
            if (twist_code != 0 && e[i] < -4 * int'(twist_code)) veto = 1;
        end
        best = -1;
        for (int i = 0; i < N; i++)
            if (hn[i] && maxwin_en[i] && (best < 0 || e[i] > e[best])) best = i;
        m_btn = hn & ~maxwin_en;
        if (best >= 0) m_btn[best] = 1'b1;
        if (veto) m_btn = '0;
        m_hold = hn;
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply();
        for (int i = 0; i < N; i++) begin
            data_word[i*DW +: DW]   = dv[i][DW-1:0];
            thresh_word[i*DW +: DW] = th[i][DW-1:0];
        end
    endtask

    // Drive at a falling edge, let one rising edge sample, check at the next falling edge.
    task automatic step(string req);
        apply();
        data_valid = 1'b1;
        @(negedge clk);
        data_valid = 1'b0;
        model_update();
        chk(req, btn_state, m_btn);
        chk(req, btn_pin, ~(opol_high ^ m_btn));
    endtask

    task automatic idle(string req, int cycles);
        apply();
        repeat (cycles) @(negedge clk);
        chk(req, btn_state, m_btn);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin dv[i] = 0; th[i] = 100; end
        apply();
        repeat (3) @(negedge clk);
        chk("R1 reset state", btn_state, 4'b0000);
        chk("R1 reset pins", btn_pin, 4'b1111);
        rst = 1'b0;
        @(negedge clk);

        step("R10 idle zero");           chk("R10", btn_state, 4'b0000);
        dv[0] = 99;  step("R2 below");   chk("R2", btn_state, 4'b0000);
        dv[0] = 100; step("R2 at");      chk("R2", btn_state, 4'b0001);
        dv[0] = 68;  step("R3 floor");   chk("R3", btn_state, 4'b0001);
        dv[0] = 67;  step("R3 under");   chk("R3", btn_state, 4'b0000);
        dv[0] = 200; idle("R9 no strobe", 3); chk("R9", btn_state, 4'b0000);
        step("R9 strobe");               chk("R9", btn_state, 4'b0001);

        twist_code = 3'd2; dv[0] = 150; dv[1] = -9;
        step("R4 veto");                 chk("R4", btn_state, 4'b0000);
        dv[1] = -8; step("R4 at margin"); chk("R4", btn_state, 4'b0001);
        twist_code = 3'd0; dv[1] = -2048;
        step("R5 disabled");             chk("R5", btn_state, 4'b0001);
        dv[1] = 0;

        maxwin_en = 4'b1111; dv[0] = 150; dv[2] = 150; dv[3] = 180;
        step("R6 winner");               chk("R6", btn_state, 4'b1000);
        dv[3] = 150; step("R6 tie");     chk("R6", btn_state, 4'b0001);
        maxwin_en = 4'b1101; dv[1] = 300;
        step("R6 outside");              chk("R6", btn_state, 4'b0011);

        maxwin_en = '0;
        for (int i = 0; i < N; i++) dv[i] = 0;
        step("R7 clear");                chk("R7", btn_state, 4'b0000);
        dpol_rise = 4'b1011; dv[2] = -2048;
        step("R7 saturate");             chk("R7", btn_state, 4'b0100);
        dv[2] = 150; step("R7 negated"); chk("R7", btn_state, 4'b0000);
        dpol_rise = '1; dv[2] = 0;

        dv[0] = 150; step("R8 press");
        opol_high = 4'b0101; #1;
        chk("R8 pins", btn_pin, 4'b1011);
        opol_high = '0;
        @(negedge clk);

        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < N; i++) begin
                dv[i] = ($urandom % 8 == 0) ? rnd(-2048, 2047) : rnd(-60, 260);
                th[i] = rnd(20, 200);
            end
            hyst_code  = 4'($urandom);
            twist_code = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom);
            maxwin_en  = 4'($urandom);
            dpol_rise  = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            opol_high  = 4'($urandom);
            if ($urandom % 5 == 0) idle("R9 random hold", 2);
            else                   step("R2 R3 R4 R6 R7 R8 random");
        end

        for (int i = 0; i < N; i++) begin dv[i] = 300; th[i] = 100; end
        maxwin_en = '0; twist_code = '0; dpol_rise = '1; opol_high = '0;
        step("R2 prefill");
        rst = 1'b1;
        @(negedge clk);
        chk("R1 midrun state", btn_state, 4'b0000);
        chk("R1 midrun pins", btn_pin, 4'b1111);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule